// File: doc/BRIEF.md
# Early-Termination Protocol Monitor for a Delayed-Data Bus

This block is a passive observer on a split-phase external bus whose data moves two cycles after each data-valid strobe. It keeps an in-order queue of the transactions issued on the request side, together with each one's length in beats. Each data-valid beat is assigned to the oldest open transaction. An abort strobe can end a transaction early on any of its beats.

The monitor flags misuse of the abort strobe, beats that no open transaction can accept, and wrong drive ownership of the data lanes at the delayed data slot. Violations set sticky flag bits and an error code that names the first violation seen. A software-visible clear pulse resets them. The address of the most recent transaction that was aborted is held on its own output. The monitor never drives the bus and never alters traffic.

Top module: `abt_bus_monitor`

## Requirements
- R1: An abort seen in a cycle without data-valid sets flag bit 0 (code 1).
- R2: An abort seen in the cycle right after another abort sets flag bit 1 (code 2).
- R3: A data-valid seen in the cycle right after an abort sets flag bit 2 (code 3). The beat is still assigned as usual.
- R4: A data-valid seen while no transaction is open sets flag bit 3 (code 4). This covers extra beats after a burst completes and beats that follow an aborted burst.
- R5: A request with `req_len` = n opens a transaction of n+1 beats. Transactions take beats strictly in issue order, and a request is visible to beats from the following cycle onward. A transaction closes on its last beat, or on any beat that carries abort. The next beat then goes to the next transaction.
- R6: For a read beat in cycle t, whether aborted or not, `ext_drv` must be 1 in cycle t+2. Otherwise flag bit 4 is set (code 5).
- R7: For a write beat in cycle t, `cpu_drv` in cycle t+2 must be 1 if the beat was not aborted and 0 if it was aborted. Otherwise flag bit 4 is set (code 5).
- R8: An abort that comes with data-valid while a transaction is open loads that transaction's address into `abort_addr` and sets `abort_addr_vld`. An abort without data-valid captures nothing.
- R9: Flag bits stay set until cleared. `err_code` is loaded only while it is 0. When several violations happen in the same cycle, the smallest code among them is chosen.
- R10: `clr_err` clears `err_flags`, `err_code` and `abort_addr_vld` in the next cycle. A clear takes priority over any violation in the same cycle.
- R11: After reset, `err_flags`, `err_code` and `abort_addr_vld` are all 0 and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_err | input | 1 | Clears flags, code and abort-valid |
| req_valid | input | 1 | A new transaction is issued this cycle |
| req_read | input | 1 | 1 = read, 0 = write |
| req_len | input | LEN_W | Number of beats minus one |
| req_addr | input | ADDR_W | Transaction address |
| dvalid | input | 1 | Data-valid strobe for one beat |
| abort | input | 1 | Ends the current transaction at this beat |
| ext_drv | input | 1 | External logic drives data and check lanes |
| cpu_drv | input | 1 | Requester drives data lanes |
| err_flags | output | 5 | Sticky violation flags, bits 0..4 per R1..R4, R6/R7 |
| err_code | output | 3 | Code of the first violation, 0 = none |
| abort_addr | output | ADDR_W | Address of the last aborted transaction |
| abort_addr_vld | output | 1 | abort_addr holds a capture since the last clear |

## Verification
The test sequences cover a complete four-beat read, a two-beat write, and a line fill aborted on its first beat followed by a one-beat read. The aborted fill checks that the next beat goes to the waiting read, and a later extra beat checks that it is reported as stray. Aborts are applied without data-valid, in two consecutive cycles, and just before a beat. Two of these cases produce several flags in the same cycle, so the bench can confirm that the code comes from the lowest violation and not from arrival order. The drive-ownership check uses reads with the external driver off, and writes with the requester driver in the wrong state for both aborted and completed beats. This shows that the delayed slot is checked in exactly cycle t+2, and that the abort state of the beat selects the expected polarity.

// File: rtl/abt_pkg.sv
package abt_pkg;
   localparam int NUM_ERR = 5;

   localparam int IDX_ABORT_NO_DV = 0;
   localparam int IDX_ABORT_B2B   = 1;
   localparam int IDX_DEAD_CYCLE  = 2;
   localparam int IDX_STRAY_BEAT  = 3;
   localparam int IDX_DRIVE       = 4;

   localparam logic [2:0] CODE_NONE = 3'd0;
endpackage

// File: rtl/abt_txn_queue.sv
module abt_txn_queue #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 2,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              push_read,
   input  logic [LEN_W-1:0]  push_len,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic              dvalid,
   input  logic              abort,
   output logic              head_vld,
   output logic              head_read,
   output logic [ADDR_W-1:0] head_addr,
   output logic              beat
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;

   logic [ADDR_W-1:0] addr_m [DEPTH];
   logic [LEN_W-1:0]  len_m  [DEPTH];
   logic [DEPTH-1:0]  read_m;
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [CNT_W-1:0]  count_q;
   logic [LEN_W-1:0]  beats_done;
   logic              push_ok, pop;

   assign head_vld  = (count_q != '0);
   assign head_read = read_m[rd_ptr];
   assign head_addr = addr_m[rd_ptr];
   assign beat      = dvalid && head_vld;
   assign pop       = beat && (abort || (beats_done == len_m[rd_ptr]));
   assign push_ok   = push && (count_q != CNT_W'(DEPTH));

   always_ff @(posedge clk) begin
      if (push_ok) begin
         addr_m[wr_ptr] <= push_addr;
         len_m[wr_ptr]  <= push_len;
         read_m[wr_ptr] <= push_read;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr     <= '0;
         rd_ptr     <= '0;
         count_q    <= '0;
         beats_done <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop)     rd_ptr <= rd_ptr + 1'b1;
         count_q <= count_q + CNT_W'(push_ok) - CNT_W'(pop);
         if (pop)       beats_done <= '0;
         else if (beat) beats_done <= beats_done + 1'b1;
      end
   end

   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (count_q == CNT_W'(DEPTH)) |-> !push);
endmodule

// File: rtl/abt_abort_rules.sv
module abt_abort_rules (
   input  logic clk,
   input  logic rst_n,
   input  logic dvalid,
   input  logic abort,
   output logic v_no_dv,
   output logic v_b2b,
   output logic v_dead
);
   logic abort_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) abort_q <= 1'b0;
      else        abort_q <= abort;
   end

   assign v_no_dv = abort && !dvalid;
   assign v_b2b   = abort && abort_q;
   assign v_dead  = dvalid && abort_q;
endmodule

// File: rtl/abt_drive_check.sv
module abt_drive_check #(
   parameter int DATA_LAG = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic beat,
   input  logic beat_read,
   input  logic beat_abort,
   input  logic ext_drv,
   input  logic cpu_drv,
   output logic v_drive
);
   logic [DATA_LAG-1:0] s_vld, s_rd, s_ab;

   generate
      if (DATA_LAG == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s_vld <= '0; s_rd <= '0; s_ab <= '0;
            end else begin
               s_vld <= beat; s_rd <= beat_read; s_ab <= beat_abort;
            end
         end
      end else begin : g_shift
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               s_vld <= '0; s_rd <= '0; s_ab <= '0;
            end else begin
               s_vld <= {s_vld[DATA_LAG-2:0], beat};
               s_rd  <= {s_rd[DATA_LAG-2:0],  beat_read};
               s_ab  <= {s_ab[DATA_LAG-2:0],  beat_abort};
            end
         end
      end
   endgenerate

   always_comb begin
      v_drive = 1'b0;
      if (s_vld[DATA_LAG-1]) begin
         if (s_rd[DATA_LAG-1])      v_drive = !ext_drv;
         else if (s_ab[DATA_LAG-1]) v_drive = cpu_drv;
         else                       v_drive = !cpu_drv;
      end
   end
endmodule

// File: rtl/abt_bus_monitor.sv
module abt_bus_monitor
   import abt_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int LEN_W    = 2,
   parameter int DEPTH    = 4,
   parameter int DATA_LAG = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_err,
   input  logic              req_valid,
   input  logic              req_read,
   input  logic [LEN_W-1:0]  req_len,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              dvalid,
   input  logic              abort,
   input  logic              ext_drv,
   input  logic              cpu_drv,
   output logic [4:0]        err_flags,
   output logic [2:0]        err_code,
   output logic [ADDR_W-1:0] abort_addr,
   output logic              abort_addr_vld
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (DATA_LAG < 1) begin : g_bad_lag
         $error("DATA_LAG must be at least 1");
      end
      if (LEN_W < 1 || ADDR_W < 1) begin : g_bad_width
         $error("LEN_W and ADDR_W must be positive");
      end
   endgenerate

   logic              head_vld, head_read, beat;
   logic [ADDR_W-1:0] head_addr;
   logic              v_no_dv, v_b2b, v_dead, v_drive;
   logic [NUM_ERR-1:0] viol;
   logic [2:0]        first_code;

   abt_txn_queue #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) u_queue (
      .clk(clk), .rst_n(rst_n),
      .push(req_valid), .push_read(req_read), .push_len(req_len), .push_addr(req_addr),
      .dvalid(dvalid), .abort(abort),
      .head_vld(head_vld), .head_read(head_read), .head_addr(head_addr), .beat(beat)
   );

   abt_abort_rules u_rules (
      .clk(clk), .rst_n(rst_n), .dvalid(dvalid), .abort(abort),
      .v_no_dv(v_no_dv), .v_b2b(v_b2b), .v_dead(v_dead)
   );

   abt_drive_check #(.DATA_LAG(DATA_LAG)) u_drive (
      .clk(clk), .rst_n(rst_n), .beat(beat), .beat_read(head_read),
      .beat_abort(abort), .ext_drv(ext_drv), .cpu_drv(cpu_drv), .v_drive(v_drive)
   );

   always_comb begin
      viol                  = '0;
      viol[IDX_ABORT_NO_DV] = v_no_dv;
      viol[IDX_ABORT_B2B]   = v_b2b;
      viol[IDX_DEAD_CYCLE]  = v_dead;
      viol[IDX_STRAY_BEAT]  = dvalid && !head_vld;
      viol[IDX_DRIVE]       = v_drive;
   end

   always_comb begin
      first_code = CODE_NONE;
      for (int i = NUM_ERR - 1; i >= 0; i--) begin
         if (viol[i]) first_code = 3'(i + 1);
      end
   end

   generate
      for (genvar g = 0; g < NUM_ERR; g++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       err_flags[g] <= 1'b0;
            else if (clr_err) err_flags[g] <= 1'b0;
            else if (viol[g]) err_flags[g] <= 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_code       <= CODE_NONE;
         abort_addr     <= '0;
         abort_addr_vld <= 1'b0;
      end else if (clr_err) begin
         err_code       <= CODE_NONE;
         abort_addr_vld <= 1'b0;
      end else begin
         if (err_code == CODE_NONE) err_code <= first_code;
         if (abort && beat) begin
            abort_addr     <= head_addr;
            abort_addr_vld <= 1'b1;
         end
      end
   end

   p_no_dv_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && !dvalid && !clr_err) |=> err_flags[0]);
   p_b2b_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && $past(abort) && !clr_err) |=> err_flags[1]);
   p_dead_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dvalid && $past(abort) && !clr_err) |=> err_flags[2]);
   p_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(abort_addr_vld) |-> $past(abort && dvalid));
   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_err |=> ((err_flags & $past(err_flags)) == $past(err_flags)));
   p_code_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_code != CODE_NONE && !clr_err) |=> $stable(err_code));
   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      clr_err |=> (err_flags == '0 && err_code == CODE_NONE && !abort_addr_vld));
endmodule

// File: tb/abt_bus_monitor_tb.sv
`timescale 1ns/1ps
module abt_bus_monitor_tb;
   localparam int AW = 32;
   localparam int LW = 2;

   typedef struct {
      string       tag;
      logic [4:0]  flags;
      logic [2:0]  code;
      logic        vld;
      logic        chk_addr;
      logic [AW-1:0] addr;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr_err = 1'b0, req_valid = 1'b0, req_read = 1'b0;
   logic [LW-1:0] req_len = '0;
   logic [AW-1:0] req_addr = '0;
   logic dvalid = 1'b0, abort = 1'b0, ext_drv = 1'b1, cpu_drv = 1'b0;
   logic [4:0] err_flags;
   logic [2:0] err_code;
   logic [AW-1:0] abort_addr;
   logic abort_addr_vld;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;
   exp_t sb[$];

   always #2.5 clk = ~clk;

   abt_bus_monitor #(.ADDR_W(AW), .LEN_W(LW), .DEPTH(4), .DATA_LAG(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .clr_err(clr_err),
      .req_valid(req_valid), .req_read(req_read), .req_len(req_len), .req_addr(req_addr),
      .dvalid(dvalid), .abort(abort), .ext_drv(ext_drv), .cpu_drv(cpu_drv),
      .err_flags(err_flags), .err_code(err_code),
      .abort_addr(abort_addr), .abort_addr_vld(abort_addr_vld)
   );

   task automatic drv(input bit rq, input bit rd, input logic [LW-1:0] ln,
                      input logic [AW-1:0] ad, input bit dv, input bit ab,
                      input bit ed, input bit cd);
      req_valid = rq; req_read = rd; req_len = ln; req_addr = ad;
      dvalid = dv; abort = ab; ext_drv = ed; cpu_drv = cd; clr_err = 1'b0;
      @(posedge clk); #1;
      req_valid = 1'b0; dvalid = 1'b0; abort = 1'b0;
   endtask

   task automatic idle(input bit ed, input bit cd);
      drv(0, 0, '0, '0, 0, 0, ed, cd);
   endtask

   task automatic clear(input bit ab);
      clr_err = 1'b1; abort = ab; dvalid = 1'b0;
      @(posedge clk); #1;
      clr_err = 1'b0; abort = 1'b0;
   endtask

   task automatic expect_st(input string tag, input logic [4:0] f, input logic [2:0] c,
                            input logic v, input bit ca, input logic [AW-1:0] a);
      exp_t e;
      e.tag = tag; e.flags = f; e.code = c; e.vld = v; e.chk_addr = ca; e.addr = a;
      sb.push_back(e);
   endtask

   always @(negedge clk) begin
      while (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         n_checks++;
         if (err_flags !== e.flags || err_code !== e.code || abort_addr_vld !== e.vld ||
             (e.chk_addr && abort_addr !== e.addr)) begin
            n_fail++;
            $display("FAIL %s: flags=%b code=%0d vld=%b addr=%h, expected flags=%b code=%0d vld=%b addr=%h",
                     e.tag, err_flags, err_code, abort_addr_vld, abort_addr,
                     e.flags, e.code, e.vld, e.addr);
         end
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      expect_st("R11 reset state", 5'h00, 3'd0, 1'b0, 0, '0);
      idle(1, 0);

      // R5/R6: complete 4-beat read, external driver on
      drv(1, 1, 2'd3, 32'h100, 0, 0, 1, 0);
      repeat (4) drv(0, 0, '0, '0, 1, 0, 1, 0);
      idle(1, 0); idle(1, 0);
      expect_st("R5 full read burst clean", 5'h00, 3'd0, 1'b0, 0, '0);

      // R7: two-beat write, requester drives in slots
      drv(1, 0, 2'd1, 32'h200, 0, 0, 1, 1);
      drv(0, 0, '0, '0, 1, 0, 1, 1);
      drv(0, 0, '0, '0, 1, 0, 1, 1);
      idle(1, 1); idle(1, 1); idle(1, 0);
      expect_st("R7 write burst clean", 5'h00, 3'd0, 1'b0, 0, '0);

      // R5/R8: line fill aborted on first beat, next beat goes to queued read
      drv(1, 1, 2'd3, 32'h300, 0, 0, 1, 0);
      drv(1, 1, 2'd0, 32'h340, 0, 0, 1, 0);
      drv(0, 0, '0, '0, 1, 1, 1, 0);
      idle(1, 0);
      drv(0, 0, '0, '0, 1, 0, 1, 0);
      idle(1, 0); idle(1, 0);
      expect_st("R5 R8 aborted fill, beat to next read", 5'h00, 3'd0, 1'b1, 1, 32'h300);
      drv(0, 0, '0, '0, 1, 0, 1, 0);
      expect_st("R4 stray beat after aborted fill", 5'h08, 3'd4, 1'b1, 1, 32'h300);
      clear(0);
      expect_st("R10 clear", 5'h00, 3'd0, 1'b0, 0, '0);

      // R1/R8: abort without data-valid, no capture
      idle(1, 0);
      drv(0, 0, '0, '0, 0, 1, 1, 0);
      expect_st("R1 abort without dvalid", 5'h01, 3'd1, 1'b0, 0, '0);
      idle(1, 0);
      clear(0);

      // R2: back-to-back aborts (also dead-cycle and stray)
      drv(1, 1, 2'd3, 32'h400, 0, 0, 1, 0);
      drv(0, 0, '0, '0, 1, 1, 1, 0);
      drv(0, 0, '0, '0, 1, 1, 1, 0);
      idle(1, 0); idle(1, 0); idle(1, 0);
      expect_st("R2 back-to-back abort", 5'h0E, 3'd2, 1'b1, 1, 32'h400);
      clear(0);

      // R3: beat right after abort, attributed to next read
      drv(1, 1, 2'd3, 32'h500, 0, 0, 1, 0);
      drv(1, 1, 2'd0, 32'h540, 0, 0, 1, 0);
      drv(0, 0, '0, '0, 1, 0, 1, 0);
      drv(0, 0, '0, '0, 1, 1, 1, 0);
      drv(0, 0, '0, '0, 1, 0, 1, 0);
      idle(1, 0); idle(1, 0);
      expect_st("R3 dead cycle violated", 5'h04, 3'd3, 1'b1, 1, 32'h500);
      clear(0);

      // R7: aborted write, requester released in slot
      drv(1, 0, 2'd3, 32'h600, 0, 0, 1, 0);
      drv(0, 0, '0, '0, 1, 1, 1, 0);
      idle(1, 0); idle(1, 0); idle(1, 0);
      expect_st("R7 aborted write released", 5'h00, 3'd0, 1'b1, 1, 32'h600);
      // R7: aborted write, requester still driving
      drv(1, 0, 2'd3, 32'h680, 0, 0, 1, 0);
      drv(0, 0, '0, '0, 1, 1, 1, 0);
      idle(1, 0);
      idle(1, 1);
      expect_st("R7 aborted write still driven", 5'h10, 3'd5, 1'b1, 1, 32'h680);
      idle(1, 0);
      clear(0);

      // R6: read slot left undriven
      drv(1, 1, 2'd0, 32'h700, 0, 0, 1, 0);
      drv(0, 0, '0, '0, 1, 0, 1, 0);
      idle(1, 0);
      idle(0, 0);
      expect_st("R6 read slot undriven", 5'h10, 3'd5, 1'b0, 0, '0);
      clear(0);

      // R7: completed write with requester not driving
      drv(1, 0, 2'd0, 32'h780, 0, 0, 1, 0);
      drv(0, 0, '0, '0, 1, 0, 1, 0);
      idle(1, 0);
      idle(1, 0);
      expect_st("R7 write slot undriven", 5'h10, 3'd5, 1'b0, 0, '0);
      clear(0);

      // R9: first violation keeps its code
      drv(0, 0, '0, '0, 0, 1, 1, 0);
      idle(1, 0);
      drv(0, 0, '0, '0, 1, 0, 1, 0);
      expect_st("R9 first code kept", 5'h09, 3'd1, 1'b0, 0, '0);
      idle(1, 0);

      // R10: clear wins over same-cycle abort; R9: simultaneous picks lowest
      clear(1);
      expect_st("R10 clear beats violation", 5'h00, 3'd0, 1'b0, 0, '0);
      drv(0, 0, '0, '0, 0, 1, 1, 0);
      expect_st("R9 simultaneous lowest code", 5'h03, 3'd1, 1'b0, 0, '0);
      idle(1, 0);
      idle(1, 0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule